// File: doc/BRIEF.md
# HDLC Host Frame Word Bridge

This block sits between a CPU bus and an HDLC framer and turns 32-bit bus words into framer byte streams and back. On the transmit side the CPU arms an end-of-packet flag and a final-word byte count in a control register, then writes data words to one of two ports. The strict port never stalls the bus. If the framer drains a word from this port and no further word is queued, the frame is aborted. The patient port holds the bus with wait states until a queue slot is free. Queued words are split into bytes and handed to the framer with a valid/ready handshake, the most significant byte first.

On the receive side, framer bytes are packed most-significant-first into words. A read of the receive data register stalls until a packed word is ready. A read-to-clear status bit reports frames that ended with a bad CRC. Every stalling access is bounded by a cycle timeout and ends with an error response if the timeout expires. Bit stuffing, flags and CRC generation belong to the framer. Here they appear only as the byte handshakes and a bad-CRC qualifier on the final received byte.

Top module: `hdlc_host_bridge`

## Requirements
- R1: After reset, bus_ack, bus_err, tx_valid and tx_abort are low, rx_ready is high, and the control and receive status registers read 0.
- R2: The register map uses word address 0 for control, 1 for strict transmit data, 2 for patient transmit data, 3 for receive data and 4 for receive status. Addresses 5 to 7 answer with bus_err. Every access ends with exactly one single-cycle pulse of bus_ack or bus_err, and a non-stalling access responds one cycle after bus_valid is sampled. The control register holds end-of-packet in bit 0, a write-only discard strobe in bit 1 (reads 0) and the final-word length in bits 3:2, and bits 31:4 read 0.
- R3: Each transmit word is sent most significant byte first. A word marked end-of-packet sends length+1 bytes (00=1, 01=2, 10=3, 11=4), with tx_last high on its final byte. Any other word sends all 4 bytes with tx_last low.
- R4: A set end-of-packet flag applies to the next word written to either transmit data port. The flag then clears on its own while the length field keeps its value.
- R5: If the framer takes the final byte of a strict-port word that is not end-of-packet and no word is queued, tx_abort pulses for one cycle and tx_valid stays low during the pulse.
- R6: A strict-port write while the queue is full answers bus_err and the word is dropped.
- R7: A patient-port write waits until the queue has room and then answers bus_ack. A gap after a patient-port word never aborts the frame.
- R8: A stalled access that does not complete within TIMEOUT_CYC cycles answers bus_err exactly TIMEOUT_CYC cycles after it was accepted, moves no data and returns read data 0.
- R9: Writing 1 to the discard bit flushes every queued and in-flight transmit word, pulses tx_abort once and clears the armed end-of-packet flag.
- R10: Received bytes are packed most-significant-first into a word. A word is complete after 4 bytes or after the frame's last byte, with unused low bytes zero. A receive data read stalls until a word is held and then returns it. A held word is kept until it is read, and rx_ready stays low meanwhile.
- R11: A last received byte flagged bad-CRC sets bit 6 of the receive status register, with all other bits 0. A read returns the bit and clears it.
- R12: While tx_valid is high and tx_ready is low, tx_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request strobe, one cycle, only while no access is open |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completed normally |
| bus_err | output | 1 | Access ended with an error |
| tx_data | output | 8 | Transmit byte to framer |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Framer accepts transmit byte |
| tx_last | output | 1 | Byte closes the frame |
| tx_abort | output | 1 | Close frame with abort sequence |
| rx_data | input | 8 | Received byte from framer |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Bridge accepts received byte |
| rx_last | input | 1 | Received byte closes the frame |
| rx_crc_bad | input | 1 | Frame ended with a CRC error, qualified by rx_last |

## Verification
The in-line assertions check several properties on every cycle. Responses are single pulses and never both kinds at once. tx_last is only raised on a valid byte, and an abort pulse never overlaps a valid byte. A stalled transmit byte and a held receive word stay stable, the queue never takes a write while full, and a bad-CRC event sets the status bit. Only the bench scenarios can show the cycle-level behaviour. This covers the byte order and length encoding, end-of-packet arming and auto-clear, and the underrun abort that applies to strict words only. It also covers the exact timeout instant and zero read data, the flush performed by discard, and partial-word receive packing.

// File: rtl/hdlc_host_pkg.sv
package hdlc_host_pkg;
  localparam int ADDR_W  = 3;
  localparam int CRC_BIT = 6;

  localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] REG_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_TXDW = 3'd2;
  localparam logic [ADDR_W-1:0] REG_RXDW = 3'd3;
  localparam logic [ADDR_W-1:0] REG_RXST = 3'd4;

  typedef struct packed {
    logic [31:0] data;
    logic        eop;
    logic [1:0]  len;
    logic        strict;
  } tx_entry_t;

  // index of the final byte sent from a word
  function automatic logic [1:0] last_idx(logic eop, logic [1:0] len);
    return eop ? len : 2'd3;
  endfunction

  // byte i of a word, byte 0 being the most significant
  function automatic logic [7:0] pick_byte(logic [31:0] w, logic [1:0] i);
    logic [4:0] sh;
    sh = 5'd24 - {i, 3'b000};
    return w[sh +: 8];
  endfunction

  // place a byte at position i of a word, position 0 being the most significant
  function automatic logic [31:0] place_byte(logic [7:0] b, logic [1:0] i);
    logic [4:0] sh;
    sh = 5'd24 - {i, 3'b000};
    return {24'b0, b} << sh;
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_host_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  tx_entry_t din,
  input  logic      pop,
  output tx_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int AW = $clog2(DEPTH);

  tx_entry_t   mem [DEPTH];
  logic [AW:0] wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign head  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end

  // R6: the bridge never offers a word to a full queue
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> !full);
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_host_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  tx_entry_t head,
  input  logic      empty,
  output logic      pop,
  output logic [7:0] tx_data,
  output logic      tx_valid,
  input  logic      tx_ready,
  output logic      tx_last,
  output logic      tx_abort
);
  tx_entry_t  cur;
  logic       busy;
  logic [1:0] idx;
  logic       abort_q;
  logic       hs, word_end, underrun;

  assign hs       = busy && tx_ready;
  assign word_end = hs && (idx == last_idx(cur.eop, cur.len));
  assign underrun = word_end && !cur.eop && cur.strict && empty;
  assign pop      = !busy && !empty && !flush;

  assign tx_valid = busy;
  assign tx_data  = pick_byte(cur.data, idx);
  assign tx_last  = busy && cur.eop && (idx == cur.len);
  assign tx_abort = abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      busy    <= 1'b0;
      idx     <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= flush || underrun;
      if (flush) begin
        busy <= 1'b0;
      end else if (pop) begin
        cur  <= head;
        busy <= 1'b1;
        idx  <= '0;
      end else if (word_end) begin
        busy <= 1'b0;
      end else if (hs) begin
        idx <= idx + 1'b1;
      end
    end
  end

  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  a_r5_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_valid);
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !flush |=> tx_valid && $stable(tx_data));
endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer
  import hdlc_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        rx_last,
  input  logic        rx_crc_bad,
  input  logic        pop,
  output logic [31:0] word,
  output logic        hold,
  output logic        crc_evt
);
  logic [31:0] acc, merged;
  logic [1:0]  cnt;
  logic        hs;

  assign rx_ready = !hold;
  assign hs       = rx_valid && rx_ready;
  assign merged   = acc | place_byte(rx_data, cnt);
  assign crc_evt  = hs && rx_last && rx_crc_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      cnt  <= '0;
      word <= '0;
      hold <= 1'b0;
    end else begin
      if (pop) hold <= 1'b0;
      if (hs) begin
        if (cnt == 2'd3 || rx_last) begin
          word <= merged;
          hold <= 1'b1;
          acc  <= '0;
          cnt  <= '0;
        end else begin
          acc <= merged;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !pop |=> hold && $stable(word));
endmodule

// File: rtl/hdlc_host_bridge.sv
module hdlc_host_bridge
  import hdlc_host_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic              tx_abort,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_last,
  input  logic              rx_crc_bad
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic              pend, r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       r_wdata;
  logic [CNT_W-1:0]  wcnt;
  logic              eop_armed, crc_sticky;
  logic [1:0]        len_q;

  logic      fifo_full, fifo_empty, ser_pop;
  tx_entry_t fifo_head, push_entry;
  logic [31:0] rx_word, rd_mux;
  logic      rx_hold, crc_evt;

  // named access events
  logic is_wait, can_go, finish, expire, mapped;
  logic wr_ctrl, discard, push, drop_full, rx_pop, st_rd;

  assign is_wait   = pend && ((r_we && r_addr == REG_TXDW) || (!r_we && r_addr == REG_RXDW));
  assign can_go    = (r_addr == REG_TXDW) ? !fifo_full : rx_hold;
  assign finish    = pend && (!is_wait || can_go);
  assign expire    = is_wait && !can_go && (wcnt == CNT_W'(TIMEOUT_CYC - 1));
  assign mapped    = (r_addr <= REG_RXST);
  assign wr_ctrl   = finish && r_we && (r_addr == REG_CTRL);
  assign discard   = wr_ctrl && r_wdata[1];
  assign push      = finish && r_we && ((r_addr == REG_TXDW) || (r_addr == REG_TXD && !fifo_full));
  assign drop_full = finish && r_we && (r_addr == REG_TXD) && fifo_full;
  assign rx_pop    = finish && !r_we && (r_addr == REG_RXDW);
  assign st_rd     = finish && !r_we && (r_addr == REG_RXST);

  always_comb begin
    push_entry.data   = r_wdata;
    push_entry.eop    = eop_armed;
    push_entry.len    = len_q;
    push_entry.strict = (r_addr == REG_TXD);
  end

  always_comb begin
    rd_mux = '0;
    if (!r_we) begin
      case (r_addr)
        REG_CTRL: rd_mux = {28'b0, len_q, 1'b0, eop_armed};
        REG_RXDW: rd_mux = rx_word;
        REG_RXST: rd_mux[CRC_BIT] = crc_sticky;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      wcnt      <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      if (!pend) begin
        if (bus_valid) begin
          pend    <= 1'b1;
          r_we    <= bus_we;
          r_addr  <= bus_addr;
          r_wdata <= bus_wdata;
          wcnt    <= '0;
        end
      end else if (finish) begin
        pend      <= 1'b0;
        bus_ack   <= mapped && !drop_full;
        bus_err   <= !mapped || drop_full;
        bus_rdata <= mapped ? rd_mux : 32'b0;
      end else if (expire) begin
        pend      <= 1'b0;
        bus_err   <= 1'b1;
        bus_rdata <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_armed  <= 1'b0;
      len_q      <= '0;
      crc_sticky <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        len_q     <= r_wdata[3:2];
        eop_armed <= r_wdata[0] && !discard;
      end else if (push) begin
        eop_armed <= 1'b0;
      end
      if (crc_evt)    crc_sticky <= 1'b1;
      else if (st_rd) crc_sticky <= 1'b0;
    end
  end

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(discard), .push(push), .din(push_entry),
    .pop(ser_pop), .head(fifo_head), .full(fifo_full), .empty(fifo_empty)
  );

  hdlc_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .flush(discard), .head(fifo_head), .empty(fifo_empty),
    .pop(ser_pop), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .tx_abort(tx_abort)
  );

  hdlc_rx_packer u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_last(rx_last), .rx_crc_bad(rx_crc_bad),
    .pop(rx_pop), .word(rx_word), .hold(rx_hold), .crc_evt(crc_evt)
  );

  a_r2_ack_xor_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));
  a_r2_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack || bus_err) |=> !(bus_ack || bus_err));
  a_r11_crc_set: assert property (@(posedge clk) disable iff (!rst_n)
    crc_evt |=> crc_sticky);
endmodule

// File: tb/hdlc_host_bridge_bench.sv
module hdlc_host_bridge_bench;
  localparam int TO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_err;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_abort;
  logic        tx_ready = 1'b1;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_bad = 1'b0;
  logic        rx_ready;

  int checks = 0, errors = 0;
  logic [7:0] cap_q[$];
  int last_cnt = 0, last_pos = 0, abort_cnt = 0;

  always #10 clk = ~clk;

  hdlc_host_bridge #(.FIFO_DEPTH(4), .TIMEOUT_CYC(TO)) u_hdlc_host_bridge (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .tx_abort(tx_abort), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_last(rx_last), .rx_crc_bad(rx_crc_bad)
  );

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_q.push_back(tx_data);
      if (tx_last) begin
        last_cnt++;
        last_pos = cap_q.size();
      end
    end
    if (rst_n && tx_abort) abort_cnt++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [2:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic ok, output logic er,
                        output int cyc);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    cyc = 0;
    ok = 1'b0; er = 1'b0;
    while (!ok && !er && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      ok = bus_ack; er = bus_err;
    end
    rd = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] rd; logic ok, er; int cyc;
    bus_op(1'b1, a, d, rd, ok, er, cyc);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] rd);
    logic ok, er; int cyc;
    bus_op(1'b0, a, 32'h0, rd, ok, er, cyc);
  endtask

  task automatic rx_put(input logic [7:0] b, input logic last, input logic bad);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_last = last; rx_crc_bad = bad;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_bad = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 ack", {31'b0, bus_ack}, 32'h0);
    chk("R1 err", {31'b0, bus_err}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 tx_abort", {31'b0, tx_abort}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    rd_reg(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd_reg(3'd4, v); chk("R1 status", v, 32'h0);
  endtask

  task automatic t_ctrl_layout();
    logic [31:0] v; logic ok, er; int cyc;
    bus_op(1'b1, 3'd0, 32'hFFFF_FFF9, v, ok, er, cyc);
    chk("R2 write ack", {31'b0, ok}, 32'h1);
    chk("R2 write latency", cyc, 1);
    rd_reg(3'd0, v); chk("R2 ctrl fields", v, 32'h9);
    wr(3'd0, 32'h0);
    bus_op(1'b0, 3'd6, 32'h0, v, ok, er, cyc);
    chk("R2 unmapped read err", {30'b0, ok, er}, 32'h1);
    bus_op(1'b1, 3'd5, 32'h0, v, ok, er, cyc);
    chk("R2 unmapped write err", {30'b0, ok, er}, 32'h1);
  endtask

  task automatic t_tx_basic();
    logic [31:0] v; int a0;
    tx_ready = 1'b1;
    a0 = abort_cnt; cap_q.delete(); last_cnt = 0;
    wr(3'd0, 32'h5);
    wr(3'd2, 32'hA1B2_C3D4);
    wait_cyc(10);
    chk("R3 len01 count", cap_q.size(), 2);
    chk("R3 msb first", {24'b0, cap_q[0]}, 32'hA1);
    chk("R3 second byte", {24'b0, cap_q[1]}, 32'hB2);
    chk("R3 last position", last_pos, 2);
    rd_reg(3'd0, v); chk("R4 eop auto clear", v, 32'h4);
    cap_q.delete(); last_cnt = 0;
    wr(3'd2, 32'h1122_3344);
    wr(3'd0, 32'hD);
    wr(3'd2, 32'h5566_7788);
    wait_cyc(12);
    chk("R3 two words count", cap_q.size(), 8);
    chk("R3 word2 first", {24'b0, cap_q[4]}, 32'h55);
    chk("R3 word2 last", {24'b0, cap_q[7]}, 32'h88);
    chk("R4 single last", last_cnt, 1);
    chk("R3 last at 8", last_pos, 8);
    chk("R7 no abort on gap", abort_cnt - a0, 0);
    cap_q.delete(); last_cnt = 0;
    wr(3'd0, 32'h9);
    wr(3'd1, 32'hCAFE_F00D);
    wait_cyc(10);
    chk("R3 len10 count", cap_q.size(), 3);
    chk("R3 len10 final", {24'b0, cap_q[2]}, 32'hF0);
    chk("R5 no abort on eop", abort_cnt - a0, 0);
  endtask

  task automatic t_underrun();
    int a0;
    a0 = abort_cnt; cap_q.delete(); last_cnt = 0;
    wr(3'd1, 32'hDEAD_BEEF);
    wait_cyc(10);
    chk("R5 bytes before abort", cap_q.size(), 4);
    chk("R5 final byte", {24'b0, cap_q[3]}, 32'hEF);
    chk("R5 no last", last_cnt, 0);
    chk("R5 abort once", abort_cnt - a0, 1);
  endtask

  task automatic t_full_discard();
    logic [31:0] v; logic ok, er; int cyc, a0, nok;
    tx_ready = 1'b0;
    cap_q.delete();
    nok = 0;
    for (int i = 1; i <= 5; i++) begin
      bus_op(1'b1, 3'd1, {8'(i), 24'h0}, v, ok, er, cyc);
      if (ok) nok++;
    end
    chk("R6 five accepted", nok, 5);
    bus_op(1'b1, 3'd1, 32'h7700_0000, v, ok, er, cyc);
    chk("R6 full err", {30'b0, ok, er}, 32'h1);
    wait_cyc(3);
    chk("R12 stall data", {23'b0, tx_valid, tx_data}, 32'h101);
    a0 = abort_cnt;
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h3);
    wait_cyc(2);
    chk("R9 abort pulse", abort_cnt - a0, 1);
    chk("R9 tx idle", {31'b0, tx_valid}, 32'h0);
    rd_reg(3'd0, v); chk("R9 eop cleared", v, 32'h0);
    tx_ready = 1'b1;
    wait_cyc(10);
    chk("R9 nothing sent", cap_q.size(), 0);
  endtask

  task automatic t_wait_tx();
    logic [31:0] v; logic ok, er; int cyc;
    logic [31:0] v2; logic ok2, er2; int cyc2;
    tx_ready = 1'b0;
    for (int i = 1; i <= 5; i++) wr(3'd1, {8'(i), 24'h0});
    bus_op(1'b1, 3'd2, 32'h9900_0000, v, ok, er, cyc);
    chk("R8 tx timeout err", {30'b0, ok, er}, 32'h1);
    chk("R8 tx timeout cycles", cyc, TO);
    fork
      bus_op(1'b1, 3'd2, 32'h8800_0000, v2, ok2, er2, cyc2);
      begin wait_cyc(6); tx_ready = 1'b1; end
    join
    chk("R7 stalled ack", {30'b0, ok2, er2}, 32'h2);
    chk("R7 stalled long", {31'b0, cyc2 > 6}, 32'h1);
    wr(3'd0, 32'h2);
    wait_cyc(10);
    cap_q.delete();
  endtask

  task automatic t_rx();
    logic [31:0] v; logic ok, er; int cyc;
    rx_put(8'h12, 1'b0, 1'b0); rx_put(8'h34, 1'b0, 1'b0);
    rx_put(8'h56, 1'b0, 1'b0); rx_put(8'h78, 1'b0, 1'b0);
    chk("R10 held blocks input", {31'b0, rx_ready}, 32'h0);
    bus_op(1'b0, 3'd3, 32'h0, v, ok, er, cyc);
    chk("R10 full word", v, 32'h1234_5678);
    chk("R10 ready latency", cyc, 1);
    rx_put(8'h9A, 1'b0, 1'b0); rx_put(8'hBC, 1'b1, 1'b0);
    rd_reg(3'd3, v); chk("R10 partial word", v, 32'h9ABC_0000);
    fork
      bus_op(1'b0, 3'd3, 32'h0, v, ok, er, cyc);
      begin wait_cyc(5); rx_put(8'hEE, 1'b1, 1'b0); end
    join
    chk("R10 stalled read data", v, 32'hEE00_0000);
    chk("R10 stalled read long", {31'b0, cyc > 5}, 32'h1);
    bus_op(1'b0, 3'd3, 32'h0, v, ok, er, cyc);
    chk("R8 rx timeout err", {30'b0, ok, er}, 32'h1);
    chk("R8 rx timeout cycles", cyc, TO);
    chk("R8 rx timeout data", v, 32'h0);
  endtask

  task automatic t_crc();
    logic [31:0] v;
    rd_reg(3'd4, v); chk("R11 clean frames", v, 32'h0);
    rx_put(8'h01, 1'b1, 1'b1);
    rd_reg(3'd3, v); chk("R11 bad frame word", v, 32'h0100_0000);
    rd_reg(3'd4, v); chk("R11 crc bit6", v, 32'h40);
    rd_reg(3'd4, v); chk("R11 read clears", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_layout();
    t_tx_basic();
    t_underrun();
    t_full_discard();
    t_wait_tx();
    t_rx();
    t_crc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule